// File: doc/BRIEF.md
# Grouped Interrupt Pending Aggregator

The block collects single-cycle or held interrupt events from a bank of pins. Each pin carries a 3-bit group field. An event on a pin sets a sticky pending bit, but only in the group that the pin's field names in that cycle. Each group keeps its own set of 32-bit pending words. Each group also drives its own interrupt line, so that pins can be steered to different upstream interrupt inputs.

Software reaches the pending words through a simple request/write-enable register port. Group g has a 64-byte window that starts at 0x800 + 0x40*g. Word w of the window, at byte offset 4*w, holds the pins 32*w to 32*w+31, and pin p sits at bit p mod 32. After its group line fires, software scans the group's words in 32-pin steps and clears the bits it has served by writing ones to them.

Top module: `irq_group_agg`

## Requirements
- R1: After reset, every pending bit is 0, every bit of irq_o is 0 and rdata_o is 0.
- R2: An event on pin p (evt_i[p]=1 at a clock edge) sets pin p's pending bit only in the group given by evt_grp_i[3p+2:3p] in that cycle. The other groups are not affected.
- R3: The pending bit of pin p in group g is bit p%32 of the word at byte address 0x800 + 0x40*g + 4*(p>>5).
- R4: A write (req_i=1, we_i=1) to a pending word clears each bit where wdata_i holds 1. It leaves each bit where wdata_i holds 0 unchanged.
- R5: If an event and a clearing write reach the same bit at the same edge, the bit stays set.
- R6: While a pin's event input is held high, writes cannot clear that pin's bit. Once the input is low, a clearing write removes the bit.
- R7: irq_o[g] equals the OR of all pending bits of group g, delayed by exactly one clock.
- R8: A read outside the implemented range returns 0, and a write there changes nothing. This covers a group index at or above NUM_GROUPS, a word index at or above ceil(NUM_PINS/32), addresses outside 0x800-0x9FF, and addresses whose low two bits are not zero.
- R9: For a read (req_i=1, we_i=0), rdata_o holds the addressed word in the cycle after the request. rdata_o is 0 in any cycle that does not follow a valid read.
- R10: Events on several pins in the same cycle, aimed at different groups, are all latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_PINS | Per-pin interrupt event, one bit per pin |
| evt_grp_i | input | 3*NUM_PINS | Group field of each pin; pin p uses bits [3p+2:3p] |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data; each 1 clears the matching pending bit |
| rdata_o | output | 32 | Read data, one cycle after the request |
| irq_o | output | NUM_GROUPS | Interrupt line of each group |

## Verification
A pending bit changes at the clock edge where an event or a write arrives, so a read issued after that edge sees the new state. Read data appears on rdata_o one edge after the request, and the bench samples it at the falling edge that follows. The group line lags the pending state by one more edge. The bench checks that line twice: once at the falling edge right after the setting edge, where it must still be low, and again one cycle later. It drives all stimulus at falling edges and samples only there, so every expected value sits at a fixed cycle offset from its cause.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int GRP_W      = 3;
  localparam int WORD_IDX_W = 4;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  // pending windows live in 0x800..0x9FF
  localparam logic [2:0] WIN_TAG = 3'b100;

  typedef struct packed {
    logic                  hit;
    logic [GRP_W-1:0]      grp;
    logic [WORD_IDX_W-1:0] word;
  } dec_t;
endpackage

// File: rtl/irq_agg_dec.sv
module irq_agg_dec
  import irq_agg_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_WORDS  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic in_win, aligned, grp_ok, word_ok;

  always_comb begin
    dec_o.grp  = addr_i[8:6];
    dec_o.word = addr_i[5:2];
    in_win     = (addr_i[11:9] == WIN_TAG);
    aligned    = (addr_i[1:0] == 2'b00);
    grp_ok     = (32'(dec_o.grp) < NUM_GROUPS);
    word_ok    = (32'(dec_o.word) < NUM_WORDS);
    dec_o.hit  = in_win && aligned && grp_ok && word_ok;
  end
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
  import irq_agg_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int GRP_ID   = 0,
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32,
  localparam int PAD       = NUM_WORDS * 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       evt_i,
  input  logic [NUM_PINS*GRP_W-1:0] evt_grp_i,
  input  logic                      wr_en_i,
  input  logic [WORD_IDX_W-1:0]     wr_word_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [PAD-1:0]            pend_o,
  output logic                      irq_o
);
  logic [PAD-1:0] set_vec, clr_vec, pend_q;
  logic           irq_q;

  for (genvar p = 0; p < PAD; p++) begin : g_bit
    if (p < NUM_PINS) begin : g_pin
      assign set_vec[p] = evt_i[p] && (evt_grp_i[p*GRP_W +: GRP_W] == GRP_W'(GRP_ID));
    end else begin : g_pad
      assign set_vec[p] = 1'b0;
    end
    assign clr_vec[p] = wr_en_i && (32'(wr_word_i) == p / 32) && wdata_i[p % 32];
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      irq_q  <= |pend_q;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  p_set_needs_evt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

  p_hold_without_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_WORDS  = 2,
  localparam int PAD = NUM_WORDS * 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_en_i,
  input  dec_t                           dec_i,
  input  logic [NUM_GROUPS-1:0][PAD-1:0] pend_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (32'(dec_i.grp) == g && 32'(dec_i.word) == w) rd_val = pend_i[g][w*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (rd_en_i && dec_i.hit) ? rd_val : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       evt_i,
  input  logic [NUM_PINS*3-1:0]     evt_grp_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [11:0]               addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_GROUPS-1:0]     irq_o
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int PAD       = NUM_WORDS * 32;

  dec_t                           dec;
  logic [NUM_GROUPS-1:0][PAD-1:0] pend;
  logic [NUM_GROUPS-1:0]          wr_g;

  irq_agg_dec #(.NUM_GROUPS(NUM_GROUPS), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign wr_g[g] = req_i && we_i && dec.hit && (32'(dec.grp) == g);

    irq_agg_bank #(.NUM_PINS(NUM_PINS), .GRP_ID(g)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i),
      .evt_grp_i (evt_grp_i),
      .wr_en_i   (wr_g[g]),
      .wr_word_i (dec.word),
      .wdata_i   (wdata_i),
      .pend_o    (pend[g]),
      .irq_o     (irq_o[g])
    );

    p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pend[g]) |=> irq_o[g]);
    p_irq_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|pend[g]) |=> !irq_o[g]);
  end

  irq_agg_rdmux #(.NUM_GROUPS(NUM_GROUPS), .NUM_WORDS(NUM_WORDS)) u_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (req_i && !we_i),
    .dec_i   (dec),
    .pend_i  (pend),
    .rdata_o (rdata_o)
  );

  p_oob_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !dec.hit) |=> (rdata_o == '0));
  p_idle_rdata_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (rdata_o == '0));
endmodule

// File: tb/irq_group_agg_test.sv
`timescale 1ns/1ps
module irq_group_agg_test;
  localparam int NP = 64;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] evt = '0;
  logic [NP*3-1:0] grp = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NG-1:0] irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_group_agg #(.NUM_PINS(NP), .NUM_GROUPS(NG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .evt_grp_i(grp),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] pa(int g, int w);
    return 12'(32'h800 + 32'h40 * g + 4 * w);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); d = rdata; req = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(int p, int g);
    @(negedge clk); grp[p*3 +: 3] = 3'(g); evt[p] = 1'b1;
    @(negedge clk); evt[p] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    for (int g = 0; g < NG; g++)
      for (int w = 0; w < 2; w++) begin
        rd(pa(g, w), d); chk("R1 pend", d, 0);
      end

    // R7 timing: low at the edge after setting, high one cycle later
    pulse(5, 2);
    chk("R7 irq lag", 32'(irq), 0);
    @(negedge clk); chk("R7 irq set", 32'(irq), 32'h4);
    wr(pa(2, 0), 32'h20);
    chk("R7 irq still high", 32'(irq), 32'h4);
    @(negedge clk); chk("R7 irq cleared", 32'(irq), 0);

    // sweep: R2 R3 R4 R9
    for (int g = 0; g < NG; g++) begin
      for (int p = 0; p < NP; p++) begin
        logic [31:0] bm;
        int og;
        bm = 32'h1 << (p % 32);
        og = (g + 3) % NG;
        pulse(p, g);
        for (int w = 0; w < 2; w++) begin
          rd(pa(g, w), d);
          chk("R3 R9 set bit", d, (w == p / 32) ? bm : 0);
        end
        rd(pa(og, p / 32), d); chk("R2 other group", d, 0);
        chk("R7 irq group", 32'(irq), 32'h1 << g);
        wr(pa(g, p / 32), ~bm);
        rd(pa(g, p / 32), d); chk("R4 zero keeps", d, bm);
        wr(pa(g, p / 32), bm);
        rd(pa(g, p / 32), d); chk("R4 one clears", d, 0);
        chk("R7 irq off", 32'(irq), 0);
      end
    end

    // R5: event and clear at the same edge
    pulse(9, 1);
    @(negedge clk); evt[9] = 1'b1; req = 1'b1; we = 1'b1; addr = pa(1, 0); wdata = 32'h200;
    @(negedge clk); evt[9] = 1'b0; req = 1'b0; we = 1'b0;
    rd(pa(1, 0), d); chk("R5 set wins", d, 32'h200);
    wr(pa(1, 0), 32'h200);
    rd(pa(1, 0), d); chk("R5 cleared later", d, 0);

    // R6: held level source
    @(negedge clk); grp[40*3 +: 3] = 3'd6; evt[40] = 1'b1;
    wr(pa(6, 1), 32'h100);
    rd(pa(6, 1), d); chk("R6 held stays", d, 32'h100);
    @(negedge clk); evt[40] = 1'b0;
    wr(pa(6, 1), 32'h100);
    rd(pa(6, 1), d); chk("R6 released clears", d, 0);

    // R10: simultaneous pins into different groups
    @(negedge clk);
    grp[3*3 +: 3] = 3'd1; grp[40*3 +: 3] = 3'd5; grp[63*3 +: 3] = 3'd5; grp[0 +: 3] = 3'd0;
    evt[3] = 1'b1; evt[40] = 1'b1; evt[63] = 1'b1; evt[0] = 1'b1;
    @(negedge clk); evt = '0;
    rd(pa(1, 0), d); chk("R10 g1", d, 32'h8);
    rd(pa(5, 1), d); chk("R10 g5", d, 32'h8000_0100);
    rd(pa(0, 0), d); chk("R10 g0", d, 32'h1);
    chk("R10 irq", 32'(irq), 32'h23);

    // R8: out-of-range writes ignored, reads zero
    wr(pa(0, 2), 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'hA00, 32'hFFFF_FFFF);
    wr(12'h801, 32'hFFFF_FFFF);
    rd(pa(0, 0), d); chk("R8 write ignored", d, 32'h1);
    rd(pa(0, 2), d); chk("R8 word oob", d, 0);
    rd(12'hA00, d); chk("R8 outside window", d, 0);
    rd(12'h000, d); chk("R8 low addr", d, 0);
    rd(12'h801, d); chk("R8 misaligned", d, 0);
    @(negedge clk); chk("R9 idle rdata", rdata, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule